// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a four-digit, time-multiplexed seven-segment display from a 16-bit word of latched BCD digits. A scan pulse advances a digit phase counter. The pulse comes either from an internal prescaler or from an external tick input. The block produces one-hot digit strobes and the segment pattern for the selected digit. Scanning runs from the most significant digit down to the least significant. Each digit holds a quarter of the scan cycle.

While the scan pulse is high, every strobe and segment is held dark. This short interval between digits prevents ghosting. Leading zeros are suppressed unless the control input inhibits it. The control input can also switch the display off entirely. In that state the scanner parks on the most significant digit. A parameter sets the output polarity for common-cathode or common-anode displays.

Top module: `seg_scan_mux`

## Requirements
- R1: After reset the digit phase selects the most significant digit (`digit_en` bit 3), and the prescaler period counter starts at zero.
- R2: With the internal tick, the scan pulse is high during the first PULSE_CYC clock cycles of every TICK_CYC-cycle period. The period counter restarts from zero after reset and after display-off.
- R3: With USE_EXT_TICK=1, `scan_tick_in` passes through one register and then serves as the scan pulse.
- R4: Each rising edge of the scan pulse moves the phase one step. The order is bit 3, 2, 1, 0 of `digit_en`, then back to bit 3. The new phase takes effect one cycle after the pulse is first seen high. At most one strobe is active at a time.
- R5: While the scan pulse is high, all digit strobes and all segments are inactive.
- R6: Digit k shows nibble `bcd_word[4k+3:4k]`. The segment bits are a=bit0 through g=bit6, using the usual glyph patterns 0x3F,06,5B,4F,66,6D,7D,07,7F,6F for 0 to 9. Codes 10 to 15 light no segment.
- R7: With `disp_ctrl` 00 or 11, leading zeros are blanked. Digit k (k≥1) has no segments lit while it and every higher nibble are zero, but its strobe is still driven. Digit 0 is never blanked.
- R8: With `disp_ctrl` 10, no leading-zero blanking takes place.
- R9: With `disp_ctrl` 01, all strobes and segments are inactive, the phase is forced to the most significant digit, and the period counter is held at zero.
- R10: With COMMON_ANODE=1, every bit of `seg_out` and `digit_en` is inverted, so both are active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_word | input | 16 | Four BCD digits; bits 15:12 are the most significant |
| disp_ctrl | input | 2 | 00 normal, 01 display off, 10 zero blanking inhibited, 11 normal |
| scan_tick_in | input | 1 | External scan pulse, used when USE_EXT_TICK=1 |
| seg_out | output | 7 | Segments a..g on bits 0..6, polarity per COMMON_ANODE |
| digit_en | output | 4 | One-hot digit strobes, bit 3 is the most significant digit |

## Verification
The bench targets the zero-suppression chain. A word such as 0x0400 must show nothing in its top digit but must show the zero below the 4. A 0x0000 word must still show a single zero in the last digit. A design that tested only the digit itself, or that also blanked the last digit, shows a wrong pattern there. The bench switches the display off in the middle of a scan and checks that it resumes at the top digit with a fresh period; a scanner that only gates outputs resumes mid-cycle. It also feeds irregular external ticks, including pulses held high for several cycles, so that a design stepping on the level instead of the edge skips digits. It applies non-BCD codes so that a decoder that does not cover all sixteen values shows false glyphs.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    typedef enum logic [1:0] {
        CTRL_NORMAL  = 2'b00,
        CTRL_DARK    = 2'b01,
        CTRL_SHOW_LZ = 2'b10,
        CTRL_ALT     = 2'b11
    } disp_ctrl_e;

    localparam int unsigned SEG_W = 7;

    // Segment a is bit 0, g is bit 6; non-decimal codes stay dark.
    function automatic logic [SEG_W-1:0] bcd_glyph(input logic [3:0] v);
        logic [SEG_W-1:0] g;
        case (v)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = 7'h00;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/scan_pulse_gen.sv
module scan_pulse_gen #(
    parameter int unsigned TICK_CYC     = 400,
    parameter int unsigned PULSE_CYC    = 16,
    parameter bit          USE_EXT_TICK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ext_tick,
    output logic pulse
);

    localparam int unsigned CNT_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TICK_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ext;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       int_pulse;

    always_comb begin
        st_d     = st_q;
        st_d.ext = ext_tick;
        if (hold) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_pulse = (st_q.cnt < PULSE_END);
    assign pulse     = USE_EXT_TICK ? st_q.ext : int_pulse;

    // R9
    hold_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.cnt == '0));

    // R2
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_q.cnt == CNT_LAST) |=> (st_q.cnt == '0));

endmodule

// File: rtl/digit_phase.sv
module digit_phase #(
    parameter int unsigned DIGITS = 4,
    parameter int unsigned PH_W   = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            pulse,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIGITS - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            prev;
    } ph_state_t;

    ph_state_t st_d, st_q;

    function automatic logic [PH_W-1:0] step_phase(input logic [PH_W-1:0] p);
        return (p == PH_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.prev = pulse;
        if (hold) begin
            st_d.phase = '0;
            st_d.prev  = 1'b1;
        end else if (pulse && !st_q.prev) begin
            st_d.phase = step_phase(st_q.phase);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    // R9
    park_msd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.phase == '0));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && pulse && !st_q.prev) |=> (st_q.phase == step_phase($past(st_q.phase))));

    // R4
    steady_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !(pulse && !st_q.prev)) |=> $stable(st_q.phase));

endmodule

// File: rtl/seg_frame.sv
module seg_frame
    import seg_scan_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    parameter int unsigned PH_W   = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic [PH_W-1:0]     phase,
    input  logic                pulse,
    input  logic [1:0]          ctrl,
    input  logic [DIGITS*4-1:0] bcd,
    output logic [SEG_W-1:0]    seg_act,
    output logic [DIGITS-1:0]   dig_act
);

    logic [3:0]        nib [DIGITS];
    logic [DIGITS-1:0] is_zero;
    logic [DIGITS-1:0] lead_zero;
    logic [PH_W-1:0]   sel;
    logic              lzb_on;
    logic              dark;
    logic              blank_lz;

    for (genvar k = 0; k < DIGITS; k++) begin : g_nib
        assign nib[k]     = bcd[4*k +: 4];
        assign is_zero[k] = (bcd[4*k +: 4] == 4'd0);
    end

    // Zero run measured from the top digit downward.
    always_comb begin
        lead_zero[DIGITS-1] = is_zero[DIGITS-1];
        for (int k = DIGITS - 2; k >= 0; k--) begin
            lead_zero[k] = is_zero[k] & lead_zero[k+1];
        end
    end

    always_comb begin
        sel      = PH_W'(DIGITS - 1) - phase;
        lzb_on   = (ctrl != CTRL_SHOW_LZ);
        dark     = (ctrl == CTRL_DARK);
        blank_lz = lzb_on && (sel != '0) && lead_zero[sel];
        seg_act  = '0;
        dig_act  = '0;
        if (!dark && !pulse) begin
            dig_act[sel] = 1'b1;
            seg_act      = blank_lz ? '0 : bcd_glyph(nib[sel]);
        end
    end

endmodule

// File: rtl/seg_scan_mux.sv
module seg_scan_mux
    import seg_scan_pkg::*;
#(
    parameter int unsigned DIGITS       = 4,
    parameter int unsigned TICK_CYC     = 400,
    parameter int unsigned PULSE_CYC    = 16,
    parameter bit          USE_EXT_TICK = 1'b0,
    parameter bit          COMMON_ANODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIGITS*4-1:0] bcd_word,
    input  logic [1:0]          disp_ctrl,
    input  logic                scan_tick_in,
    output logic [SEG_W-1:0]    seg_out,
    output logic [DIGITS-1:0]   digit_en
);

    localparam int unsigned PH_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [SEG_W-1:0]  SEG_MASK = {SEG_W{COMMON_ANODE}};
    localparam logic [DIGITS-1:0] DIG_MASK = {DIGITS{COMMON_ANODE}};

    logic              scan_off;
    logic              pulse;
    logic [PH_W-1:0]   phase;
    logic [SEG_W-1:0]  seg_act;
    logic [DIGITS-1:0] dig_act;

    assign scan_off = (disp_ctrl == CTRL_DARK);

    scan_pulse_gen #(
        .TICK_CYC    (TICK_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .USE_EXT_TICK(USE_EXT_TICK)
    ) i_scan_pulse_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (scan_off),
        .ext_tick(scan_tick_in),
        .pulse   (pulse)
    );

    digit_phase #(
        .DIGITS(DIGITS),
        .PH_W  (PH_W)
    ) i_digit_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (scan_off),
        .pulse(pulse),
        .phase(phase)
    );

    seg_frame #(
        .DIGITS(DIGITS),
        .PH_W  (PH_W)
    ) i_seg_frame (
        .phase  (phase),
        .pulse  (pulse),
        .ctrl   (disp_ctrl),
        .bcd    (bcd_word),
        .seg_act(seg_act),
        .dig_act(dig_act)
    );

    assign seg_out  = seg_act ^ SEG_MASK;
    assign digit_en = dig_act ^ DIG_MASK;

    // R5
    blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (dig_act == '0 && seg_act == '0));

    // R9
    off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_off |-> (dig_act == '0 && seg_act == '0));

    // R4
    onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_act));

    // R7
    lsd_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_off && !pulse && dig_act[0] && bcd_word[3:0] <= 4'd9) |-> (seg_act != '0));

endmodule

// File: tb/test_seg_scan_mux.sv
module test_seg_scan_mux;

    localparam time CLK_PERIOD = 10ns;
    localparam int  TCK = 10;
    localparam int  PLS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bcd_word = 16'h0;
    logic [1:0]  disp_ctrl = 2'b00;
    logic        scan_tick_in = 1'b0;
    logic [6:0]  seg_a, seg_b;
    logic [3:0]  dig_a, dig_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    // model state
    int a_cnt = 0, a_phase = 0, b_phase = 0;
    bit a_prev = 1, b_prev = 1, b_ext = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_scan_mux #(.TICK_CYC(TCK), .PULSE_CYC(PLS), .USE_EXT_TICK(1'b0), .COMMON_ANODE(1'b0))
    i_seg_scan_mux (
        .clk(clk), .rst_n(rst_n), .bcd_word(bcd_word), .disp_ctrl(disp_ctrl),
        .scan_tick_in(scan_tick_in), .seg_out(seg_a), .digit_en(dig_a));

    seg_scan_mux #(.USE_EXT_TICK(1'b1), .COMMON_ANODE(1'b1))
    i_seg_scan_mux_ext (
        .clk(clk), .rst_n(rst_n), .bcd_word(bcd_word), .disp_ctrl(disp_ctrl),
        .scan_tick_in(scan_tick_in), .seg_out(seg_b), .digit_en(dig_b));

    function automatic logic [6:0] glyph(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
            4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
            4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
            4'd9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    function automatic logic [10:0] expect_out(int phase, bit pulse, logic [1:0] ctrl,
                                               logic [15:0] d, bit ca);
        int sel;
        bit lz;
        logic [6:0] s;
        logic [3:0] g;
        sel = 3 - phase;
        lz = 1;
        for (int j = 3; j >= sel; j--) if (d[j*4 +: 4] != 4'd0) lz = 0;
        s = 7'h00;
        g = 4'h0;
        if (ctrl != 2'b01 && !pulse) begin
            g[sel] = 1'b1;
            s = (ctrl != 2'b10 && sel != 0 && lz) ? 7'h00 : glyph(d[sel*4 +: 4]);
        end
        if (ca) begin
            s = ~s;
            g = ~g;
        end
        return {s, g};
    endfunction

    function automatic string situation(bit pulse, logic [1:0] ctrl);
        if (ctrl == 2'b01) return "R9";
        if (pulse) return "R5";
        if (ctrl == 2'b10) return "R8";
        return "R7";
    endfunction

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        bit pa, pb;
        bit hold;
        if (!rst_n) begin
            a_cnt = 0; a_phase = 0; a_prev = 1;
            b_ext = 0; b_phase = 0; b_prev = 1;
        end else begin
            hold = (disp_ctrl == 2'b01);
            pa = (a_cnt < PLS);
            pb = b_ext;
            if (hold) begin
                a_cnt = 0; a_phase = 0; a_prev = 1;
                b_phase = 0; b_prev = 1;
            end else begin
                a_cnt = (a_cnt == TCK - 1) ? 0 : a_cnt + 1;
                if (pa && !a_prev) a_phase = (a_phase + 1) % 4;
                if (pb && !b_prev) b_phase = (b_phase + 1) % 4;
                a_prev = pa;
                b_prev = pb;
            end
            b_ext = scan_tick_in;
        end
        started = 1;
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        logic [10:0] ea, eb;
        if (started && !done) begin
            ea = expect_out(a_phase, a_cnt < PLS, disp_ctrl, bcd_word, 1'b0);
            eb = expect_out(b_phase, b_ext, disp_ctrl, bcd_word, 1'b1);
            n_cmp++;
            if ({seg_a, dig_a} !== ea) begin
                n_bad++;
                $display("FAIL %s/%s internal-tick: got seg=%h dig=%h exp seg=%h dig=%h",
                         cur_req, situation(a_cnt < PLS, disp_ctrl), seg_a, dig_a, ea[10:4], ea[3:0]);
            end
            n_cmp++;
            if ({seg_b, dig_b} !== eb) begin
                n_bad++;
                $display("FAIL %s/R10/R3 ext-tick: got seg=%h dig=%h exp seg=%h dig=%h",
                         cur_req, seg_b, dig_b, eb[10:4], eb[3:0]);
            end
        end
    end

    // background external tick: short and long pulses at irregular spacing
    always @(negedge clk) begin
        if (!rst_n) scan_tick_in <= 1'b0;
        else if (scan_tick_in) scan_tick_in <= ($urandom % 3 == 0);
        else scan_tick_in <= ($urandom % 6 == 0);
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic show(logic [15:0] d, logic [1:0] c, int n);
        @(negedge clk);
        bcd_word = d;
        disp_ctrl = c;
        run(n);
    endtask

    initial begin
        void'($urandom(32'd4417));
        run(4);
        // R1: reset state compared while reset is held (top digit, counter at zero)
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R2";
        show(16'h1234, 2'b00, 40);
        cur_req = "R4";
        show(16'h8642, 2'b00, 80);
        cur_req = "R6";
        show(16'h9876, 2'b00, 40);
        show(16'h5555, 2'b00, 40);
        show(16'h3A0F, 2'b00, 40);
        show(16'hBCDE, 2'b10, 40);
        cur_req = "R7";
        show(16'h0000, 2'b00, 40);
        show(16'h0007, 2'b00, 40);
        show(16'h0400, 2'b00, 40);
        show(16'h0010, 2'b11, 40);
        show(16'h0A00, 2'b00, 40);
        cur_req = "R8";
        show(16'h0005, 2'b10, 40);
        show(16'h0000, 2'b10, 40);
        cur_req = "R9";
        show(16'h2468, 2'b00, 17);
        show(16'h2468, 2'b01, 13);
        show(16'h2468, 2'b00, 45);
        show(16'h0090, 2'b01, 3);
        show(16'h0090, 2'b00, 25);
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            logic [15:0] d;
            for (int k = 0; k < 4; k++) begin
                int r;
                r = $urandom % 16;
                d[k*4 +: 4] = (r < 4) ? 4'd0 : ((r < 14) ? 4'($urandom % 10) : 4'($urandom % 16));
            end
            show(d, 2'($urandom % 4), 1 + ($urandom % 30));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        done = 1;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule